// File: doc/BRIEF.md
# Degrading Two-out-of-Three Word Voter

This block takes three copies of one data word, one from each of three redundant channels, together with a single strobe that marks when all three copies are valid. On each strobed cycle it votes on the words and, one clock later, drives out a voted word, a flag that marks that word as valid, the code of a channel it has judged faulty, a warning for the operator display, and a combined multiple-failure and brake command. A match means that two words are equal in every bit.

The voter starts in full triple voting. On the first disagreement in which exactly one channel differs from the other two, it drops that channel for good and keeps running as a pair comparator on the two channels that remain. If the pair then disagrees, or if all three channels differ while triple voting is still active, it goes into a safe state. In that state the voted output is cut off and the brake stays applied until the next reset. Excluded channels are never brought back.

Top module: `tmr_degrade_voter`

## Requirements
- R1: After reset, out_vld, warn, multi_fail and brake are 0, bad_chan is 0 and out_data is all zeros.
- R2: In triple mode, a strobed cycle with all three words equal gives out_data equal to that word and out_vld = 1 on the next cycle, with warn still 0.
- R3: In triple mode, a strobed cycle in which exactly one word differs from the other two gives the majority word with out_vld = 1 on the next cycle. From that cycle on, bad_chan names the odd channel (1 = chan_a, 2 = chan_b, 3 = chan_c), warn is 1, and the block is in pair mode.
- R4: In pair mode the excluded channel has no effect. When the two remaining words are equal, their common value is given with out_vld = 1 one cycle later.
- R5: In pair mode, a strobed cycle in which the two remaining words differ sets multi_fail and brake to 1 on the next cycle. In that cycle out_vld is 0 and out_data is all zeros.
- R6: In triple mode, a strobed cycle in which all three words differ from each other gives the same result as R5, and bad_chan stays 0.
- R7: The safe state holds until reset. Later strobes give out_vld = 0, and multi_fail and brake stay at 1. A reset brings back triple mode.
- R8: Once bad_chan is nonzero, it keeps its value until reset.
- R9: A cycle with in_vld = 0 does not vote. The next cycle has out_vld = 0, out_data keeps its value, and the mode does not change, whatever the three words hold.
- R10: Matching is exact. Two words that differ in a single bit count as a disagreement.
- R11: Results are registered with one cycle of latency. Back-to-back strobes give one result per cycle, and out_vld is never 1 unless in_vld was 1 on the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Strobe that qualifies all three channel words |
| chan_a | input | DATA_W | Word from channel 1 |
| chan_b | input | DATA_W | Word from channel 2 |
| chan_c | input | DATA_W | Word from channel 3 |
| out_data | output | DATA_W | Voted word, all zeros in the safe state |
| out_vld | output | 1 | Voted word valid |
| bad_chan | output | 2 | Excluded channel code: 0 none, 1 to 3 the channel |
| warn | output | 1 | Operator warning: a channel has been excluded |
| multi_fail | output | 1 | Multiple-failure indication (safe state) |
| brake | output | 1 | Emergency brake command (safe state) |

## Verification
Every result of a vote, including the voted word and its valid flag, the excluded-channel code, the warning and the safe-state outputs, is due on the clock edge that samples the strobe. It can therefore be seen one cycle after the stimulus. The bench drives inputs on the falling edge and updates a behavioural model at the rising edge from the values it drove. Shortly after each rising edge it compares every output with that model, so each check lands in the cycle where the result first appears and repeats in every cycle after it. That makes holding behaviour in the idle, pair and safe phases visible as well.

// File: rtl/tv_pkg.sv
package tv_pkg;
  localparam int NUM_CH = 3;

  typedef enum logic [1:0] {
    MODE_TRIPLE = 2'd0,
    MODE_PAIR   = 2'd1,
    MODE_SAFE   = 2'd2
  } vote_mode_e;

  // channel codes as seen on bad_chan
  localparam logic [1:0] CH_NONE = 2'd0;
  localparam logic [1:0] CH_A    = 2'd1;
  localparam logic [1:0] CH_B    = 2'd2;
  localparam logic [1:0] CH_C    = 2'd3;

  // forwarding selector (array index)
  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_C = 2'd2;
endpackage

// File: rtl/tv_match_net.sv
module tv_match_net
  import tv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] ch [NUM_CH],
  output logic [NUM_CH-1:0] eq_ring
);
  // eq_ring[0]=a==b, eq_ring[1]=b==c, eq_ring[2]=c==a ; exact bitwise (R10)
  for (genvar i = 0; i < NUM_CH; i++) begin : g_pair
    localparam int J = (i + 1) % NUM_CH;
    assign eq_ring[i] = (ch[i] == ch[J]);
  end
endmodule

// File: rtl/tv_mode_ctrl.sv
module tv_mode_ctrl
  import tv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [NUM_CH-1:0] eq_ring,
  output logic             fwd_en,
  output logic [1:0]       fwd_sel,
  output logic             go_safe,
  output vote_mode_e       mode_q,
  output logic [1:0]       excl_q
);
  logic       eq_ab, eq_bc, eq_ca, pair_eq;
  logic [1:0] pair_sel;
  vote_mode_e mode_d;
  logic [1:0] excl_d;

  assign eq_ab = eq_ring[0];
  assign eq_bc = eq_ring[1];
  assign eq_ca = eq_ring[2];

  // surviving pair in degraded mode
  always_comb begin
    case (excl_q)
      CH_A:    begin pair_eq = eq_bc; pair_sel = SEL_B; end
      CH_B:    begin pair_eq = eq_ca; pair_sel = SEL_A; end
      default: begin pair_eq = eq_ab; pair_sel = SEL_A; end
    endcase
  end

  always_comb begin
    mode_d  = mode_q;
    excl_d  = excl_q;
    fwd_en  = 1'b0;
    fwd_sel = SEL_A;
    go_safe = 1'b0;
    if (in_vld) begin
      case (mode_q)
        MODE_TRIPLE: begin
          if (eq_ab && eq_bc) begin
            fwd_en = 1'b1;
          end else if (eq_ab) begin
            fwd_en = 1'b1; excl_d = CH_C; mode_d = MODE_PAIR;
          end else if (eq_bc) begin
            fwd_en = 1'b1; fwd_sel = SEL_B; excl_d = CH_A; mode_d = MODE_PAIR;
          end else if (eq_ca) begin
            fwd_en = 1'b1; excl_d = CH_B; mode_d = MODE_PAIR;
          end else begin
            go_safe = 1'b1; mode_d = MODE_SAFE;
          end
        end
        MODE_PAIR: begin
          if (pair_eq) begin
            fwd_en = 1'b1; fwd_sel = pair_sel;
          end else begin
            go_safe = 1'b1; mode_d = MODE_SAFE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_TRIPLE;
      excl_q <= CH_NONE;
    end else if (in_vld) begin
      mode_q <= mode_d;
      excl_q <= excl_d;
    end
  end

  assert_safe_absorbing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SAFE) |=> (mode_q == MODE_SAFE));
  assert_no_return_triple_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != MODE_TRIPLE) |=> (mode_q != MODE_TRIPLE));
  assert_excl_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (excl_q != CH_NONE) |=> $stable(excl_q));
endmodule

// File: rtl/tv_out_stage.sv
module tv_out_stage
  import tv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ch [NUM_CH],
  input  logic              fwd_en,
  input  logic [1:0]        fwd_sel,
  input  logic              go_safe,
  output logic [DATA_W-1:0] out_data,
  output logic              out_vld
);
  logic [DATA_W-1:0] pick;
  logic [DATA_W-1:0] data_d;
  logic              data_en;

  always_comb begin
    case (fwd_sel)
      SEL_B:   pick = ch[1];
      SEL_C:   pick = ch[2];
      default: pick = ch[0];
    endcase
  end

  always_comb begin
    data_en = fwd_en | go_safe;
    data_d  = go_safe ? '0 : pick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_vld  <= 1'b0;
    end else begin
      out_vld <= fwd_en;
      if (data_en) out_data <= data_d;
    end
  end

  assert_vld_not_with_safe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    go_safe |=> (!out_vld && out_data == '0));
endmodule

// File: rtl/tmr_degrade_voter.sv
module tmr_degrade_voter
  import tv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] chan_a,
  input  logic [DATA_W-1:0] chan_b,
  input  logic [DATA_W-1:0] chan_c,
  output logic [DATA_W-1:0] out_data,
  output logic              out_vld,
  output logic [1:0]        bad_chan,
  output logic              warn,
  output logic              multi_fail,
  output logic              brake
);
  logic [DATA_W-1:0] ch [NUM_CH];
  logic [NUM_CH-1:0] eq_ring;
  logic              fwd_en, go_safe;
  logic [1:0]        fwd_sel;
  vote_mode_e        mode_q;
  logic [1:0]        excl_q;

  assign ch[0] = chan_a;
  assign ch[1] = chan_b;
  assign ch[2] = chan_c;

  tv_match_net #(.DATA_W(DATA_W)) u_match (
    .ch(ch), .eq_ring(eq_ring)
  );

  tv_mode_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .eq_ring(eq_ring),
    .fwd_en(fwd_en), .fwd_sel(fwd_sel), .go_safe(go_safe),
    .mode_q(mode_q), .excl_q(excl_q)
  );

  tv_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .ch(ch), .fwd_en(fwd_en), .fwd_sel(fwd_sel),
    .go_safe(go_safe), .out_data(out_data), .out_vld(out_vld)
  );

  assign bad_chan   = excl_q;
  assign warn       = (excl_q != CH_NONE);
  assign multi_fail = (mode_q == MODE_SAFE);
  assign brake      = (mode_q == MODE_SAFE);

  assert_vld_excludes_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> !multi_fail);
  assert_one_cycle_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));
endmodule

// File: tb/tmr_degrade_voter_bench.sv
module tmr_degrade_voter_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_vld = 1'b0;
  logic [W-1:0] a = '0, b = '0, c = '0;
  logic [W-1:0] out_data;
  logic         out_vld, warn, multi_fail, brake;
  logic [1:0]   bad_chan;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  tmr_degrade_voter #(.DATA_W(W)) u_tmr_degrade_voter (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .chan_a(a), .chan_b(b), .chan_c(c),
    .out_data(out_data), .out_vld(out_vld), .bad_chan(bad_chan),
    .warn(warn), .multi_fail(multi_fail), .brake(brake)
  );

  // behavioural model: 0 triple, 1 pair, 2 safe
  int           m_mode = 0;
  int           m_excl = 0;
  logic [W-1:0] m_data = '0;
  bit           m_vld = 0;

  task automatic chk(input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    logic [W-1:0] sa, sb, sc;
    bit sv, sr;
    sa = a; sb = b; sc = c; sv = in_vld; sr = rst_n;
    #1;
    if (!sr) begin
      m_mode = 0; m_excl = 0; m_data = '0; m_vld = 0;
    end else begin
      m_vld = 0;
      if (sv && m_mode == 0) begin
        if (sa == sb && sb == sc) begin m_data = sa; m_vld = 1; end
        else if (sa == sb) begin m_data = sa; m_vld = 1; m_excl = 3; m_mode = 1; end
        else if (sb == sc) begin m_data = sb; m_vld = 1; m_excl = 1; m_mode = 1; end
        else if (sa == sc) begin m_data = sa; m_vld = 1; m_excl = 2; m_mode = 1; end
        else begin m_data = '0; m_mode = 2; end
      end else if (sv && m_mode == 1) begin
        logic [W-1:0] p, q;
        if (m_excl == 1) begin p = sb; q = sc; end
        else if (m_excl == 2) begin p = sa; q = sc; end
        else begin p = sa; q = sb; end
        if (p == q) begin m_data = p; m_vld = 1; end
        else begin m_data = '0; m_mode = 2; end
      end
    end
    if (!done) begin
      chk("out_data", out_data, m_data);
      chk("out_vld", out_vld, m_vld);
      chk("bad_chan", bad_chan, m_excl);
      chk("warn", warn, m_excl != 0);
      chk("multi_fail", multi_fail, m_mode == 2);
      chk("brake", brake, m_mode == 2);
    end
  end

  task automatic drive(input logic [W-1:0] xa, input logic [W-1:0] xb,
                       input logic [W-1:0] xc, input bit v, input string t);
    @(negedge clk);
    a = xa; b = xb; c = xc; in_vld = v; tag = t;
  endtask

  task automatic do_reset(input string t);
    @(negedge clk);
    tag = t; in_vld = 0; rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #20000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset("R1");
    drive(16'h0, 16'h0, 16'h0, 0, "R1");
    drive(16'h0, 16'h0, 16'h0, 0, "R1");
    // R2 all equal
    drive(16'h1234, 16'h1234, 16'h1234, 1, "R2");
    drive(16'hFFFF, 16'hFFFF, 16'hFFFF, 1, "R2");
    drive(16'h0000, 16'h0000, 16'h0000, 1, "R2");
    drive(16'hA5A5, 16'hA5A5, 16'hA5A5, 1, "R2");
    // R9 no strobe with disagreeing words
    drive(16'h1111, 16'h2222, 16'h3333, 0, "R9");
    drive(16'h1111, 16'h1111, 16'h3333, 0, "R9");
    // R11 back-to-back strobes
    for (int i = 0; i < 6; i++) drive(W'(i * 37 + 5), W'(i * 37 + 5), W'(i * 37 + 5), 1, "R11");
    // R10 single bit diff on chan_c -> R3 exclude C
    drive(16'h0F0F, 16'h0F0F, 16'h0F0E, 1, "R10");
    drive(16'h0F0F, 16'h0F0F, 16'h0F0F, 0, "R3");
    // R4 chan_c ignored
    drive(16'h7777, 16'h7777, 16'hDEAD, 1, "R4");
    drive(16'h8001, 16'h8001, 16'h0000, 1, "R4");
    drive(16'h4242, 16'h4242, 16'h4242, 1, "R8");
    drive(16'h9999, 16'h9999, 16'h1111, 0, "R9");
    // R5 pair disagree
    drive(16'h5555, 16'h5554, 16'h5555, 1, "R5");
    drive(16'h6666, 16'h6666, 16'h6666, 1, "R7");
    drive(16'h6666, 16'h6666, 16'h6666, 1, "R7");
    drive(16'h6666, 16'h6666, 16'h6666, 0, "R7");
    do_reset("R7");
    drive(16'h3C3C, 16'h3C3C, 16'h3C3C, 1, "R7");
    // R6 all differ
    drive(16'h0001, 16'h0002, 16'h0004, 1, "R6");
    drive(16'h0001, 16'h0001, 16'h0001, 1, "R6");
    do_reset("R1");
    // R3 chan_a odd, then pair b/c
    drive(16'hAAAA, 16'hBBBB, 16'hBBBB, 1, "R3");
    drive(16'h0000, 16'hC0DE, 16'hC0DE, 1, "R4");
    drive(16'h1234, 16'h4321, 16'h4321, 1, "R8");
    drive(16'hC0DE, 16'hC0DE, 16'hC0DF, 1, "R5");
    do_reset("R1");
    // R3 chan_b odd, then pair a/c
    drive(16'h2468, 16'h2469, 16'h2468, 1, "R3");
    drive(16'h1357, 16'hFFFF, 16'h1357, 1, "R4");
    drive(16'h1357, 16'h1357, 16'h1358, 1, "R5");
    drive(16'h0, 16'h0, 16'h0, 0, "R7");
    drive(16'h0, 16'h0, 16'h0, 0, "R7");
    finish_run();
  end
endmodule